// File: doc/BRIEF.md
# Polled Serial Port with Byte Register Bus

The block is an 8-bit asynchronous serial transmitter and receiver. Its line format is fixed at one start bit, eight data bits sent least significant bit first, no parity and one stop bit. It sits on a simple synchronous register bus that is one byte wide. The bus has four word slots, chosen by a 2-bit word index: a data buffer, a status register, and the low and high bytes of the bit period.

Software drives the block by polling. It reads the status flags, writes a byte to send and reads a byte that has arrived. Two sticky event flags record each completed transmission and each received character, and software clears them by writing ones. A single-cycle interrupt strobe marks the same events for logic that prefers not to poll.

The bit period, counted in clock cycles, defaults to the clock frequency divided by the baud rate (50 MHz and 19200 baud unless overridden). A build parameter decides whether software may change the period at run time or whether it stays fixed at the default.

Top module: `uart_regs`

## Requirements
- R1: The transmit line idles high. A frame is a low start bit, eight data bits least significant first and a high stop bit, and each bit lasts P clock cycles, where P is the current bit period.
- R2: After reset `txd_o` is high, `irq_o` is low and the status register reads 0x01.
- R3: Status layout: bit 0 = transmit ready, bit 1 = receive ready, bit 4 = transmit event, bit 5 = receive event. A data write (index 0) while transmit ready is high clears transmit ready at that clock edge. Transmit ready rises 10*P cycles later, and the transmit event flag and a one-cycle `irq_o` pulse appear at the same edge.
- R4: A data write while transmit ready is low is dropped. No second frame is sent and the frame in progress is unchanged.
- R5: Writing the data buffer does not clear the transmit event flag.
- R6: A received frame places its byte in the receive buffer. Receive ready and the receive event flag rise at the same edge, together with a one-cycle `irq_o` pulse.
- R7: A read at index 0 returns the received byte and clears receive ready. It leaves the receive event flag set.
- R8: A status write (index 1) clears bit 4 and/or bit 5 only where the written bit is 1. It never changes the ready bits. Bits 2, 3, 6 and 7 always read 0.
- R9: When the period is programmable, writes at index 2 and index 3 set the low and high byte of P. Reads at those indices return the status register.
- R10: When the period is fixed, writes at index 2 and 3 are ignored and P stays CLK_HZ/BAUD.
- R11: The receiver passes the line through a two-flop synchronizer. It samples the start bit at half a period and discards a start bit that is high again at that point.
- R12: `irq_o` is high only in a cycle in which a transmit or receive event flag has just been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register word index (0 data, 1 status, 2 period low, 3 period high) |
| we_i | input | 1 | Write strobe, one per cycle held |
| re_i | input | 1 | Read strobe; a data read clears receive ready |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| irq_o | output | 1 | One-cycle event strobe |
| txd_o | output | 1 | Serial transmit line |
| rxd_i | input | 1 | Serial receive line |

## Verification
Transmit ready is polled once per cycle from the negative edge that follows the accepting write edge. It must first read high on exactly the 10*P-th sample, and `irq_o` must be high in that same sample and low in the next. The transmit line is sampled at mid-bit, P/2 cycles after the first low sample and then every P cycles, so any error in the bit period or the bit order shows up on a sample. A received frame takes about 9.5*P cycles plus three cycles of synchronizer and state latency, so the receive flags are checked once the full 10*P-cycle drive has ended. The false-start case is checked after three more periods of idle line.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned BAUD_W = 16;

  localparam logic [1:0] IDX_DATA = 2'd0;
  localparam logic [1:0] IDX_STAT = 2'd1;
  localparam logic [1:0] IDX_PLO  = 2'd2;
  localparam logic [1:0] IDX_PHI  = 2'd3;

  localparam int unsigned ST_TXRDY = 0;
  localparam int unsigned ST_RXRDY = 1;
  localparam int unsigned ST_TXEV  = 4;
  localparam int unsigned ST_RXEV  = 5;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_tx.sv
module uart_tx import uart_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] period_i,
  input  logic              load_i,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              txd_o
);
  logic [BAUD_W-1:0] cnt_q;
  logic [3:0]        bit_q;
  logic [8:0]        shift_q;
  logic              busy_q, txd_q;
  logic              bit_end;

  assign bit_end = (cnt_q == period_i - BAUD_W'(1));
  assign done_o  = busy_q && bit_end && (bit_q == 4'd9);
  assign busy_o  = busy_q;
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; bit_q <= '0; shift_q <= '1; busy_q <= 1'b0; txd_q <= 1'b1;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q  <= 1'b1;
        txd_q   <= 1'b0;               // start bit
        shift_q <= {1'b1, data_i};     // stop bit rides behind data
        cnt_q   <= '0;
        bit_q   <= '0;
      end
    end else if (bit_end) begin
      cnt_q <= '0;
      if (bit_q == 4'd9) begin
        busy_q <= 1'b0;
      end else begin
        txd_q   <= shift_q[0];
        shift_q <= {1'b1, shift_q[8:1]};
        bit_q   <= bit_q + 4'd1;
      end
    end else begin
      cnt_q <= cnt_q + BAUD_W'(1);
    end
  end
endmodule

// File: rtl/uart_rx.sv
module uart_rx import uart_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BAUD_W-1:0] period_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [7:0]        data_o
);
  rx_state_e         st_q;
  logic [1:0]        sync_q;
  logic [BAUD_W-1:0] cnt_q, half;
  logic [2:0]        bit_q;
  logic [7:0]        shift_q;
  logic              rx_s, bit_end;

  assign rx_s    = sync_q[1];
  assign half    = period_i >> 1;
  assign bit_end = (cnt_q == period_i - BAUD_W'(1));
  assign done_o  = (st_q == RX_STOP) && bit_end;
  assign data_o  = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11; st_q <= RX_IDLE; cnt_q <= '0; bit_q <= '0; shift_q <= '0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      unique case (st_q)
        RX_IDLE: begin
          cnt_q <= '0;
          if (!rx_s) st_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == half - BAUD_W'(1)) begin
            cnt_q <= '0;
            bit_q <= '0;
            st_q  <= rx_s ? RX_IDLE : RX_DATA;  // glitch rejection
          end else cnt_q <= cnt_q + BAUD_W'(1);
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[7:1]};
            bit_q   <= bit_q + 3'd1;
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end else cnt_q <= cnt_q + BAUD_W'(1);
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_q <= '0;
            st_q  <= RX_IDLE;
          end else cnt_q <= cnt_q + BAUD_W'(1);
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_regs.sv
module uart_regs import uart_pkg::*; #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BAUD      = 19_200,
  parameter bit          PROG_BAUD = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       we_i,
  input  logic       re_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       txd_o,
  input  logic       rxd_i
);
  localparam int unsigned       DIV   = CLK_HZ / BAUD;
  localparam logic [BAUD_W-1:0] DEF_P = BAUD_W'(DIV);

  logic [BAUD_W-1:0] period;
  logic       tx_busy, tx_done, tx_load, rx_done;
  logic [7:0] rx_shift, rx_buf_q, status;
  logic       tx_ev_q, rx_ev_q, rx_rdy_q, irq_q;
  logic       wr_data, wr_stat, rd_data;

  assign wr_data = we_i && (addr_i == IDX_DATA);
  assign wr_stat = we_i && (addr_i == IDX_STAT);
  assign rd_data = re_i && (addr_i == IDX_DATA);
  assign tx_load = wr_data && !tx_busy;

  generate
    if (PROG_BAUD) begin : g_prog
      logic [BAUD_W-1:0] period_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) period_q <= DEF_P;
        else if (we_i && addr_i == IDX_PLO) period_q[7:0] <= wdata_i;
        else if (we_i && addr_i == IDX_PHI) period_q[BAUD_W-1:8] <= wdata_i;
      end
      assign period = period_q;
    end else begin : g_fixed
      assign period = DEF_P;
    end
  endgenerate

  uart_tx u_tx (
    .clk_i, .rst_ni, .period_i(period), .load_i(tx_load), .data_i(wdata_i),
    .busy_o(tx_busy), .done_o(tx_done), .txd_o
  );

  uart_rx u_rx (
    .clk_i, .rst_ni, .period_i(period), .rxd_i, .done_o(rx_done), .data_o(rx_shift)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_ev_q <= 1'b0; rx_ev_q <= 1'b0; rx_rdy_q <= 1'b0; irq_q <= 1'b0; rx_buf_q <= '0;
    end else begin
      // set wins over a clear in the same cycle
      tx_ev_q  <= tx_done | (tx_ev_q & ~(wr_stat & wdata_i[ST_TXEV]));
      rx_ev_q  <= rx_done | (rx_ev_q & ~(wr_stat & wdata_i[ST_RXEV]));
      rx_rdy_q <= rx_done | (rx_rdy_q & ~rd_data);
      irq_q    <= tx_done | rx_done;
      if (rx_done) rx_buf_q <= rx_shift;
    end
  end

  always_comb begin
    status           = '0;
    status[ST_TXRDY] = !tx_busy;
    status[ST_RXRDY] = rx_rdy_q;
    status[ST_TXEV]  = tx_ev_q;
    status[ST_RXEV]  = rx_ev_q;
  end

  assign rdata_o = (addr_i == IDX_DATA) ? rx_buf_q : status;
  assign irq_o   = irq_q;
endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       txd_o,
  input logic       tx_busy,
  input logic       tx_ev,
  input logic       rx_rdy,
  input logic       rx_ev
);
  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  a_r3_load_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && !tx_busy) |=> tx_busy);

  a_r3_ready_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_busy) |-> (tx_ev && irq_o));

  a_r5_write_keeps_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd0 && tx_ev) |=> tx_ev);

  a_r6_rx_ready_with_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_rdy) |-> (rx_ev && irq_o));

  a_r7_read_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 2'd0) |=> (!rx_rdy || irq_o));

  a_r7_read_keeps_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 2'd0 && rx_ev && !we_i) |=> rx_ev);

  a_r8_zero_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != 2'd0) |-> (rdata_o[3:2] == 2'b00 && rdata_o[7:6] == 2'b00));

  a_r8_clear_only_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 2'd1 && !wdata_i[4] && tx_ev) |=> tx_ev);

  a_r12_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (tx_ev || rx_ev));
endmodule

bind uart_regs uart_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .re_i(re_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .txd_o(txd_o),
  .tx_busy(tx_busy), .tx_ev(tx_ev_q), .rx_rdy(rx_rdy_q), .rx_ev(rx_ev_q)
);

// File: tb/uart_regs_test.sv
module uart_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0, re = 1'b0, fx_we = 1'b0, fx_re = 1'b0, rxd = 1'b1;
  wire  [7:0] rdata, fx_rdata;
  wire        irq, txd, fx_irq, fx_txd;

  int checks = 0, fails = 0, cur_p = 16;
  byte unsigned tx_q[$], rx_q[$];

  uart_regs #(.CLK_HZ(50_000_000), .BAUD(3_125_000), .PROG_BAUD(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .txd_o(txd), .rxd_i(rxd));

  uart_regs #(.CLK_HZ(50_000_000), .BAUD(3_125_000), .PROG_BAUD(1'b0)) uut_fixed (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(fx_we), .re_i(fx_re), .wdata_i(wdata),
    .rdata_o(fx_rdata), .irq_o(fx_irq), .txd_o(fx_txd), .rxd_i(1'b1));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit fx, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d;
    if (fx) fx_we = 1'b1; else we = 1'b1;
    @(negedge clk); we = 1'b0; fx_we = 1'b0;
  endtask

  task automatic rd(input bit fx, input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    if (fx) fx_re = 1'b1; else re = 1'b1;
    #1 d = fx ? fx_rdata : rdata;
    @(posedge clk); #1 re = 1'b0; fx_re = 1'b0;
  endtask

  task automatic send_tx(input byte unsigned b);
    tx_q.push_back(b);
    wr(1'b0, 2'd0, b);
  endtask

  // called right after the accepting write; sample n follows edge write+n
  task automatic wait_txrdy(input bit fx, output int n);
    logic [7:0] s;
    logic       ir;
    n = 0;
    addr = 2'd1;
    if (fx) fx_re = 1'b1; else re = 1'b1;
    do begin
      @(negedge clk); n++;
      s  = fx ? fx_rdata : rdata;
      ir = fx ? fx_irq : irq;
    end while (!s[0] && n < 5000);
    chk("R3", "irq high with ready", int'(ir), 1);
    chk("R3", "tx event with ready", int'(s[4]), 1);
    @(negedge clk);
    chk("R12", "irq one cycle", int'(fx ? fx_irq : irq), 0);
    re = 1'b0; fx_re = 1'b0;
  endtask

  task automatic drive_rx(input byte unsigned b, input bit check);
    logic [7:0] d;
    rx_q.push_back(b);
    @(posedge clk); #1 rxd = 1'b0;
    repeat (cur_p) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      #1 rxd = b[i];
      repeat (cur_p) @(posedge clk);
    end
    #1 rxd = 1'b1;
    repeat (cur_p) @(posedge clk);
    if (check) begin
      rd(1'b0, 2'd1, d);
      chk("R6", "rx ready", int'(d[1]), 1);
      chk("R6", "rx event", int'(d[5]), 1);
      rd(1'b0, 2'd0, d);
      chk("R6", "rx byte", int'(d), int'(rx_q.pop_front()));
      rd(1'b0, 2'd1, d);
      chk("R7", "ready cleared by read", int'(d[1]), 0);
      chk("R7", "event kept after read", int'(d[5]), 1);
    end
  endtask

  // scoreboard monitor for the transmit line
  initial begin
    logic [7:0] got;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (cur_p / 2) @(negedge clk);
        chk("R1", "start bit low", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
          repeat (cur_p) @(negedge clk);
          got[i] = txd;
        end
        repeat (cur_p) @(negedge clk);
        chk("R1", "stop bit high", int'(txd), 1);
        if (tx_q.size() == 0) chk("R4", "unexpected frame", int'(got), 'h100);
        else chk("R1", "tx frame data", int'(got), int'(tx_q.pop_front()));
      end
    end
  end

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R2", "txd after reset", int'(txd), 1);
    chk("R2", "irq after reset", int'(irq), 0);
    rd(1'b0, 2'd1, d); chk("R2", "status after reset", int'(d), 'h01);
    rd(1'b0, 2'd2, d); chk("R9", "period low reads status", int'(d), 'h01);

    // basic transmit and ready timing
    send_tx(8'hA5);
    wait_txrdy(1'b0, n);
    chk("R3", "ready after 10P", n, 10 * cur_p);

    // write while busy; event survives data write
    send_tx(8'h3C);
    rd(1'b0, 2'd1, d);
    chk("R5", "event kept on tx write", int'(d[4]), 1);
    chk("R3", "ready low while busy", int'(d[0]), 0);
    wr(1'b0, 2'd0, 8'hFF);
    wait_txrdy(1'b0, n);
    repeat (3 * cur_p) @(negedge clk);
    chk("R4", "dropped byte not queued", tx_q.size(), 0);
    chk("R4", "line idle after", int'(txd), 1);

    // write-1-to-clear
    wr(1'b0, 2'd1, 8'h00);
    rd(1'b0, 2'd1, d); chk("R8", "zero write keeps flags", int'(d), 'h11);
    wr(1'b0, 2'd1, 8'hEF);
    rd(1'b0, 2'd1, d); chk("R8", "other bits no effect", int'(d), 'h11);
    wr(1'b0, 2'd1, 8'h10);
    rd(1'b0, 2'd1, d); chk("R8", "tx event cleared", int'(d), 'h01);

    // receive
    drive_rx(8'h5A, 1'b1);
    drive_rx(8'h81, 1'b1);
    wr(1'b0, 2'd1, 8'h20);
    rd(1'b0, 2'd1, d); chk("R8", "rx event cleared", int'(d), 'h01);

    // false start rejected
    @(posedge clk); #1 rxd = 1'b0;
    repeat (4) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (3 * cur_p) @(posedge clk);
    rd(1'b0, 2'd1, d); chk("R11", "glitch not received", int'(d), 'h01);
    drive_rx(8'h00, 1'b1);
    wr(1'b0, 2'd1, 8'h30);

    // programmable period
    wr(1'b0, 2'd2, 8'd20);
    wr(1'b0, 2'd3, 8'd0);
    cur_p = 20;
    rd(1'b0, 2'd3, d); chk("R9", "period high reads status", int'(d), 'h01);
    send_tx(8'h96);
    wait_txrdy(1'b0, n);
    chk("R9", "ready after 10 new periods", n, 200);
    drive_rx(8'hC3, 1'b1);
    repeat (2 * cur_p) @(negedge clk);

    // fixed period instance ignores period writes
    wr(1'b1, 2'd2, 8'd5);
    wr(1'b1, 2'd3, 8'd0);
    wr(1'b1, 2'd0, 8'h77);
    wait_txrdy(1'b1, n);
    chk("R10", "fixed period unchanged", n, 160);
    rd(1'b1, 2'd1, d); chk("R10", "fixed status", int'(d), 'h11);

    chk("R1", "all frames seen", tx_q.size(), 0);
    finish_run();
  end
endmodule